// File: doc/BRIEF.md
# Burst-Splitting DMA Channel Engine

This block is the state machine of a single DMA channel. It copies a buffer of 32-bit words from a source address to a destination address. It drives a request/response initiator port that moves one word per request. The copy runs as a sequence of bursts. For each burst the engine issues all of the reads, collects the returned words in a small internal burst buffer, and then issues the matching writes to the destination.

The size of each burst is the smallest of four values: the maximum burst, the bytes left to copy, the bytes left before the next burst-aligned boundary of the source address, and the same distance for the destination address. A misaligned region is therefore cut into two transactions at the boundary, and the last burst may be short.

A start pulse loads the configuration. An abort pulse asks the channel to stop. The abort is deferred: no new request is issued, and every request already accepted is allowed to return its response before the channel goes idle. An error response on a read or on a write ends the transfer with an error code. A transfer that completes its whole length ends with a success code and a one-cycle completion event.

Top module: `dma_burst_engine`

## Requirements
- R1: While reset is held and right after it, `status` is 0 (idle), `req_valid` is 0 and `done_evt` is 0.
- R2: A started transfer of N bytes, where N is a non-zero multiple of 4, leaves the N destination bytes equal to the source bytes. The word just past the destination end is left unwritten. `status` becomes 2 (done) and `done_evt` pulses exactly once.
- R3: Each burst moves min(BURST_BYTES, remaining bytes, bytes to the next BURST_BYTES-aligned source boundary, bytes to the next BURST_BYTES-aligned destination boundary). Each burst is one uninterrupted run of read requests.
- R4: Every read of a burst has been accepted and has returned its response before the first write of that burst is issued. The source and destination addresses advance by the same byte count.
- R5: A start with a length below 4 bytes issues no request. It sets `status` to 2 and pulses `done_evt` one cycle after the start.
- R6: An error response to a read halts the transfer with `status` 3. No write of the failing burst is issued, and `done_evt` does not pulse.
- R7: An error response to a write halts the transfer with `status` 4. No later burst is started, and `done_evt` does not pulse.
- R8: After an abort pulse during a transfer, at most one further request is accepted, and only in the cycle of the pulse itself. Responses to accepted requests are still consumed. `status` then returns to 0 without a `done_evt` pulse, and a later start runs normally.
- R9: A start pulse while `status` is 1 (busy) is ignored.
- R10: An abort pulse while the channel is not busy sets `status` to 0 one cycle later.
- R11: Requests are issued only while `status` is 1, and every request address is a multiple of 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that launches a transfer |
| abort | input | 1 | One-cycle pulse that requests a deferred stop |
| cfg_src | input | ADDR_W | Source start address, multiple of 4 |
| cfg_dst | input | ADDR_W | Destination start address, multiple of 4 |
| cfg_len | input | LEN_W | Transfer length in bytes, multiple of 4 |
| status | output | 3 | 0 idle, 1 busy, 2 done, 3 read error, 4 write error |
| done_evt | output | 1 | One-cycle pulse when a transfer completes successfully |
| req_valid | output | 1 | A request is presented |
| req_ready | input | 1 | The request is accepted in this cycle |
| req_write | output | 1 | 1 for a write request, 0 for a read request |
| req_addr | output | ADDR_W | Word address of the request, in bytes |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | A response for the oldest accepted request |
| rsp_err | input | 1 | The response reports a bus error |
| rsp_rdata | input | 32 | Read data carried by the response |

## Verification
The hardest state to reach is an abort that arrives while requests are accepted but their responses are still in flight. In that state the engine must stop issuing requests while it keeps counting the responses that drain. The bench reaches it by toggling `req_ready` every cycle during a four-burst copy and pulsing abort part way through. It then counts every accepted request from the second cycle after the pulse, and that count must be zero. It also checks that the channel settles idle with no completion event, and that a following transfer runs normally. Error responses are injected at chosen word addresses so that a read error falls inside the second burst and a write error falls inside the first.

// File: rtl/dma_burst_pkg.sv
// Shared definitions for the burst DMA channel engine.
// Assumes 32-bit data words and byte addresses.
package dma_burst_pkg;
    localparam int WORD_W = 32;

    // Externally visible channel status codes
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_BUSY   = 3'd1,
        ST_DONE   = 3'd2,
        ST_RD_ERR = 3'd3,
        ST_WR_ERR = 3'd4
    } chan_status_t;

    // Internal sequencing states
    typedef enum logic [1:0] {
        E_IDLE  = 2'd0,
        E_PLAN  = 2'd1,
        E_READ  = 2'd2,
        E_WRITE = 2'd3
    } eng_state_t;
endpackage

// File: rtl/dma_burst_sizer.sv
// Computes the word count of the next burst as the minimum of the maximum
// burst, the remaining length, and the distances to the next burst-aligned
// boundary of the source and destination addresses.
// Assumes BURST_WORDS is a power of two >= 2 and rem is a multiple of 4.
module dma_burst_sizer #(
    parameter int BURST_WORDS = 4,
    parameter int LEN_W       = 16,
    localparam int WOFF_W     = $clog2(BURST_WORDS),
    localparam int CNT_W      = $clog2(BURST_WORDS + 1)
) (
    input  logic [WOFF_W-1:0] src_woff,
    input  logic [WOFF_W-1:0] dst_woff,
    input  logic [LEN_W-1:0]  rem,
    output logic [CNT_W-1:0]  words
);
    logic [LEN_W-1:0] rem_words;
    logic [CNT_W-1:0] rem_cap, to_src, to_dst, edge_min;

    // Distance limits in words, then the overall minimum
    always_comb begin
        rem_words = rem >> 2;
        rem_cap   = (rem_words >= LEN_W'(BURST_WORDS)) ? CNT_W'(BURST_WORDS)
                                                      : rem_words[CNT_W-1:0];
        to_src    = CNT_W'(BURST_WORDS) - CNT_W'(src_woff);
        to_dst    = CNT_W'(BURST_WORDS) - CNT_W'(dst_woff);
        edge_min  = (to_src < to_dst) ? to_src : to_dst;
        words     = (edge_min < rem_cap) ? edge_min : rem_cap;
    end
endmodule

// File: rtl/dma_burst_buffer.sv
// Word store holding one burst between its read phase and its write phase.
// Assumes one write per cycle and a combinational read port.
module dma_burst_buffer #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Capture a returned read word into its slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                slot[i] <= wr_data;
            end
        end
    end

    // Present the slot selected by the write-phase index
    always_comb rd_data = slot[rd_idx];
endmodule

// File: rtl/dma_req_tracker.sv
// Counts requests issued and responses received within the current phase.
// Assumes responses return in request order, one per accepted request.
module dma_req_tracker #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             issue,
    input  logic             retire,
    output logic [CNT_W-1:0] issued,
    output logic [CNT_W-1:0] retired
);
    // Phase counters, cleared at each phase start
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            issued  <= '0;
            retired <= '0;
        end else begin
            if (issue)  issued  <= issued + 1'b1;
            if (retire) retired <= retired + 1'b1;
        end
    end
endmodule

// File: rtl/dma_burst_engine.sv
// One DMA channel: copies a word-aligned buffer in bursts. All reads of a
// burst complete before its writes start. Aborts are deferred until every
// accepted request has responded. Assumes in-order responses, a 32-bit data
// path, aligned configuration, and BURST_BYTES a power of two >= 8.
module dma_burst_engine
    import dma_burst_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 16,
    parameter int BURST_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [ADDR_W-1:0] cfg_src,
    input  logic [ADDR_W-1:0] cfg_dst,
    input  logic [LEN_W-1:0]  cfg_len,
    output logic [2:0]        status,
    output logic              done_evt,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [WORD_W-1:0] req_wdata,
    input  logic              rsp_valid,
    input  logic              rsp_err,
    input  logic [WORD_W-1:0] rsp_rdata
);
    localparam int BURST_WORDS = BURST_BYTES / 4;
    localparam int CNT_W       = $clog2(BURST_WORDS + 1);
    localparam int IDX_W       = $clog2(BURST_WORDS);
    localparam int OFF_W       = $clog2(BURST_BYTES);

    eng_state_t        state_q;
    chan_status_t      status_q;
    logic              done_q, abort_q, err_q;
    logic [ADDR_W-1:0] src_q, dst_q;
    logic [LEN_W-1:0]  rem_q;
    logic [CNT_W-1:0]  bw_q, plan_words, issued, retired;
    logic [LEN_W-1:0]  bytes_q;
    logic              active, halt, accept, rd_last, wr_last, drained, clr;

    dma_burst_sizer #(.BURST_WORDS(BURST_WORDS), .LEN_W(LEN_W)) u_sizer (
        .src_woff (src_q[OFF_W-1:2]),
        .dst_woff (dst_q[OFF_W-1:2]),
        .rem      (rem_q),
        .words    (plan_words)
    );

    dma_req_tracker #(.CNT_W(CNT_W)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .issue   (accept),
        .retire  (rsp_valid),
        .issued  (issued),
        .retired (retired)
    );

    dma_burst_buffer #(.DEPTH(BURST_WORDS), .DATA_W(WORD_W)) u_buf (
        .clk     (clk),
        .wr_en   (state_q == E_READ && rsp_valid),
        .wr_idx  (retired[IDX_W-1:0]),
        .wr_data (rsp_rdata),
        .rd_idx  (issued[IDX_W-1:0]),
        .rd_data (req_wdata)
    );

    // Request generation and phase-end conditions
    always_comb begin
        active    = (state_q == E_READ) || (state_q == E_WRITE);
        halt      = abort_q || err_q;
        req_valid = active && !halt && (issued < bw_q);
        req_write = (state_q == E_WRITE);
        req_addr  = (req_write ? dst_q : src_q) + ADDR_W'({issued, 2'b00});
        accept    = req_valid && req_ready;
        bytes_q   = LEN_W'({bw_q, 2'b00});
        rd_last   = (state_q == E_READ) && rsp_valid && !rsp_err && !halt
                    && (retired == bw_q - 1'b1);
        wr_last   = (state_q == E_WRITE) && rsp_valid && !rsp_err && !halt
                    && (retired == bw_q - 1'b1);
        drained   = active && halt && (issued == retired);
        clr       = (state_q == E_PLAN) || rd_last;
    end

    // Channel sequencing, status and completion event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= E_IDLE;
            status_q <= ST_IDLE;
            done_q   <= 1'b0;
            abort_q  <= 1'b0;
            err_q    <= 1'b0;
            src_q    <= '0;
            dst_q    <= '0;
            rem_q    <= '0;
            bw_q     <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                E_IDLE: begin
                    if (abort) begin
                        status_q <= ST_IDLE;
                    end else if (start) begin
                        if (cfg_len < LEN_W'(4)) begin
                            status_q <= ST_DONE;
                            done_q   <= 1'b1;
                        end else begin
                            src_q    <= cfg_src;
                            dst_q    <= cfg_dst;
                            rem_q    <= cfg_len & ~LEN_W'(3);
                            abort_q  <= 1'b0;
                            err_q    <= 1'b0;
                            status_q <= ST_BUSY;
                            state_q  <= E_PLAN;
                        end
                    end
                end
                E_PLAN: begin
                    bw_q    <= plan_words;
                    state_q <= E_READ;
                    if (abort) abort_q <= 1'b1;
                end
                default: begin
                    if (abort) abort_q <= 1'b1;
                    if (rsp_valid && rsp_err) err_q <= 1'b1;
                    if (drained) begin
                        state_q  <= E_IDLE;
                        abort_q  <= 1'b0;
                        err_q    <= 1'b0;
                        if (abort_q)                 status_q <= ST_IDLE;
                        else if (state_q == E_READ)  status_q <= ST_RD_ERR;
                        else                         status_q <= ST_WR_ERR;
                    end else if (rd_last) begin
                        state_q <= E_WRITE;
                    end else if (wr_last) begin
                        src_q <= src_q + ADDR_W'(bytes_q);
                        dst_q <= dst_q + ADDR_W'(bytes_q);
                        rem_q <= rem_q - bytes_q;
                        if (rem_q == bytes_q) begin
                            state_q  <= E_IDLE;
                            abort_q  <= 1'b0;
                            status_q <= abort ? ST_IDLE : ST_DONE;
                            done_q   <= !abort;
                        end else begin
                            state_q <= E_PLAN;
                        end
                    end
                end
            endcase
        end
    end

    assign status   = status_q;
    assign done_evt = done_q;
endmodule

// File: rtl/dma_burst_engine_chk.sv
// Protocol checker for the burst DMA channel engine, bound to every instance.
// Assumes in-order responses on the initiator port.
module dma_burst_engine_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              abort,
    input logic [2:0]        status,
    input logic              done_evt,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid
);
    logic [7:0] out_cnt;
    logic       last_rd, abort_seen;

    // Outstanding requests, kind of last accepted request, pending abort
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_cnt    <= '0;
            last_rd    <= 1'b0;
            abort_seen <= 1'b0;
        end else begin
            out_cnt <= out_cnt + 8'(req_valid && req_ready) - 8'(rsp_valid);
            if (req_valid && req_ready) last_rd <= !req_write;
            if (abort && status == 3'd1) abort_seen <= 1'b1;
            else if (status != 3'd1)     abort_seen <= 1'b0;
        end
    end

    p_req_only_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> status == 3'd1);
    p_word_aligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_addr[1:0] == 2'b00);
    p_done_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |-> status == 3'd2);
    p_busy_no_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        status == 3'd1 |-> !done_evt);
    p_reads_before_writes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && last_rd) |-> out_cnt == 8'd0);
    p_halt_no_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_seen |-> !req_valid);
    p_rd_err_from_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd3 && $past(status) != 3'd3) |-> $past(status) == 3'd1);
endmodule

bind dma_burst_engine dma_burst_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (abort),
    .status    (status),
    .done_evt  (done_evt),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid)
);

// File: tb/dma_burst_engine_bench.sv
module dma_burst_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, abort = 1'b0;
    logic [31:0] cfg_src = '0, cfg_dst = '0;
    logic [15:0] cfg_len = '0;
    logic [2:0]  status;
    logic        done_evt, req_valid, req_write;
    logic [31:0] req_addr, req_wdata;
    logic        req_ready;
    logic        rsp_valid = 1'b0, rsp_err = 1'b0;
    logic [31:0] rsp_rdata = '0;

    logic [31:0] mem [256];
    logic        throttle = 1'b0, ready_tog = 1'b1;
    logic        err_en = 1'b0, post_abort = 1'b0, prev_rd = 1'b0;
    logic [31:0] err_addr = '0;
    int          rd_runs = 0, rd_acc = 0, post_acc = 0, done_cnt = 0;
    int          checks = 0, errors = 0;
    bit          finished = 0;

    always #5 clk = ~clk;
    assign req_ready = throttle ? ready_tog : 1'b1;

    dma_burst_engine u_dma_burst_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_len(cfg_len),
        .status(status), .done_evt(done_evt),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    // Memory model with one-cycle response latency and error injection
    always @(posedge clk) begin
        rsp_valid <= req_valid && req_ready;
        rsp_err   <= req_valid && req_ready && err_en && (req_addr == err_addr);
        if (done_evt) done_cnt <= done_cnt + 1;
        if (status != 3'd1) prev_rd <= 1'b0;
        if (req_valid && req_ready) begin
            if (post_abort) post_acc <= post_acc + 1;
            if (req_write) begin
                prev_rd <= 1'b0;
                if (!(err_en && req_addr == err_addr)) mem[req_addr[9:2]] <= req_wdata;
            end else begin
                rsp_rdata <= mem[req_addr[9:2]];
                rd_acc    <= rd_acc + 1;
                prev_rd   <= 1'b1;
                if (!prev_rd || status != 3'd1) rd_runs <= rd_runs + 1;
            end
        end
    end

    always @(negedge clk) ready_tog <= throttle ? ~ready_tog : 1'b1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic prep(input int seed);
        for (int i = 0; i < 128; i++) mem[i] = {8'(seed), 8'hA5, 16'(i)};
        for (int i = 128; i < 256; i++) mem[i] = '0;
    endtask

    function automatic int diff_words(input int s, input int d, input int len);
        int bad = 0;
        for (int i = 0; i < len / 4; i++)
            if (mem[8'((d >> 2) + i)] != mem[8'((s >> 2) + i)]) bad++;
        return bad;
    endfunction

    function automatic int nonzero_words(input int a, input int len);
        int bad = 0;
        for (int i = 0; i < len / 4; i++)
            if (mem[8'((a >> 2) + i)] != 32'd0) bad++;
        return bad;
    endfunction

    task automatic pulse_start(input int s, input int d, input int len);
        @(negedge clk);
        cfg_src = 32'(s); cfg_dst = 32'(d); cfg_len = 16'(len); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse_abort();
        @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (status == 3'd1 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(n < 3000, req, n, 0);
        repeat (2) @(negedge clk);
    endtask

    // Vector table: source, destination, length, expected burst count
    localparam int NV = 7;
    localparam int VSRC [NV] = '{'h000, 'h000, 'h008, 'h004, 'h01C, 'h000, 'h00C};
    localparam int VDST [NV] = '{'h200, 'h200, 'h200, 'h20C, 'h300, 'h300, 'h204};
    localparam int VLEN [NV] = '{16, 40, 16, 12, 4, 0, 28};
    localparam int VBUR [NV] = '{1, 3, 2, 2, 1, 0, 4};

    initial begin
        int d0, r0, a0;
        prep(0);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(status == 3'd0, "R1 status", int'(status), 0);
        chk(!req_valid, "R1 req_valid", int'(req_valid), 0);
        chk(!done_evt, "R1 done_evt", int'(done_evt), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(status == 3'd0 && !req_valid, "R1 after release", int'(status), 0);

        // Table walk: R2 copy, R3 burst sizing, R5 zero length
        for (int v = 0; v < NV; v++) begin
            prep(v + 1);
            throttle = v[0];
            d0 = done_cnt; r0 = rd_runs;
            pulse_start(VSRC[v], VDST[v], VLEN[v]);
            wait_idle("R2 timeout");
            chk(status == 3'd2, "R2 status done", int'(status), 2);
            chk(done_cnt - d0 == 1, "R2 single done_evt", done_cnt - d0, 1);
            chk(rd_runs - r0 == VBUR[v], "R3 burst count", rd_runs - r0, VBUR[v]);
            chk(diff_words(VSRC[v], VDST[v], VLEN[v]) == 0, "R2 data copy",
                diff_words(VSRC[v], VDST[v], VLEN[v]), 0);
            chk(nonzero_words(VDST[v] + VLEN[v], 4) == 0, "R2 guard word",
                nonzero_words(VDST[v] + VLEN[v], 4), 0);
        end
        throttle = 1'b0;

        // R6: read error in the second burst
        prep(20); d0 = done_cnt;
        err_en = 1'b1; err_addr = 32'h014;
        pulse_start('h000, 'h200, 32);
        wait_idle("R6 timeout");
        chk(status == 3'd3, "R6 read error status", int'(status), 3);
        chk(diff_words('h000, 'h200, 16) == 0, "R6 first burst written", diff_words('h000, 'h200, 16), 0);
        chk(nonzero_words('h210, 16) == 0, "R6 failing burst not written", nonzero_words('h210, 16), 0);
        chk(done_cnt == d0, "R6 no done_evt", done_cnt - d0, 0);

        // R10: abort while not busy clears the error status
        @(negedge clk); abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        chk(status == 3'd0, "R10 abort when idle", int'(status), 0);

        // R7: write error in the first burst
        prep(21); d0 = done_cnt;
        err_addr = 32'h208;
        pulse_start('h000, 'h200, 32);
        wait_idle("R7 timeout");
        chk(status == 3'd4, "R7 write error status", int'(status), 4);
        chk(nonzero_words('h210, 16) == 0, "R7 no later burst", nonzero_words('h210, 16), 0);
        chk(done_cnt == d0, "R7 no done_evt", done_cnt - d0, 0);
        err_en = 1'b0;

        // R8: abort with requests in flight under back-pressure
        prep(22); d0 = done_cnt;
        throttle = 1'b1;
        pulse_start('h000, 'h200, 64);
        repeat (7) @(negedge clk);
        chk(status == 3'd1, "R8 busy before abort", int'(status), 1);
        pulse_abort();
        a0 = post_acc; post_abort = 1'b1;
        wait_idle("R8 timeout");
        post_abort = 1'b0;
        chk(post_acc == a0, "R8 no request after abort", post_acc - a0, 0);
        chk(status == 3'd0, "R8 idle after drain", int'(status), 0);
        chk(done_cnt == d0, "R8 no done_evt", done_cnt - d0, 0);
        chk(!rsp_valid && !req_valid, "R8 quiet after drain", int'(req_valid), 0);
        throttle = 1'b0;
        prep(23);
        pulse_start('h000, 'h200, 16);
        wait_idle("R8 restart timeout");
        chk(status == 3'd2 && diff_words('h000, 'h200, 16) == 0, "R8 restart copy", int'(status), 2);

        // R9: start while busy is ignored
        prep(24); d0 = done_cnt; a0 = rd_acc;
        pulse_start('h000, 'h200, 32);
        repeat (2) @(negedge clk);
        pulse_start('h040, 'h300, 16);
        wait_idle("R9 timeout");
        chk(rd_acc - a0 == 8, "R9 read count of first transfer only", rd_acc - a0, 8);
        chk(nonzero_words('h300, 16) == 0, "R9 second target untouched", nonzero_words('h300, 16), 0);
        chk(done_cnt - d0 == 1 && diff_words('h000, 'h200, 32) == 0, "R9 first copy", done_cnt - d0, 1);

        // R5: sub-word length issues nothing and completes next cycle
        d0 = done_cnt; a0 = rd_acc;
        pulse_start('h000, 'h200, 2);
        chk(status == 3'd2, "R5 done at once", int'(status), 2);
        repeat (2) @(negedge clk);
        chk(done_cnt - d0 == 1 && rd_acc == a0, "R5 no requests", rd_acc - a0, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule